// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block is the bus-side engine of a processor. It runs one read or one write at a time over a shared address/data bus. A request port supplies five things for each transfer: a 20-bit address, the write data, the direction, a high-byte select and a memory-or-I/O select. The sequencer accepts a request only while it is idle. It then steps through four clock phases, called T1, T2, T3 and T4. It drives the address latch strobe, the active-low read and write strobes, the active-low data-buffer enable, the direction and space indicators and the active-low high-byte enable.

The low bus lines carry the address in T1. After T1 they carry write data, or they are released so that the device can drive read data. The upper lines carry the top address bits in T1 and a status code after T1. A slow device holds `ready` low to stretch the transfer by whole clocks. The captured read data comes back with a one-clock `done` pulse.

Top module: `mux_bus_seq`

## Requirements
- R1: `req_ready` is high only while idle. A `req_valid` seen while busy is ignored: it starts no transfer and latches nothing.
- R2: In T1, which is the clock after acceptance, `ale` is high for exactly one clock. In that clock `ad_out` carries address bits 15:0 with `ad_oe` high, and `as_out` carries address bits 19:16.
- R3: `bhe_n` is low only in T1, and only when the high byte was requested. At all other times it is high.
- R4: `rd_n` (read) or `wr_n` (write) is low, together with `den_n`, from T2 through the last of T3 or the wait states. All three are high in T4 and while idle. `rd_n` and `wr_n` are never low together.
- R5: For a write, `ad_out` carries the write data with `ad_oe` high from T2 through T4.
- R6: For a read, `ad_oe` is low from T2 through T4.
- R7: `ready` is sampled at the end of T2 and at the end of each wait state, and never at the end of T3. A low sample at T2 inserts one wait state after T3. Each low sample in a wait state adds one more. A transfer with N waits lasts 4+N clocks, counted from T1 through T4.
- R8: For a read, `rdata` takes the value of `ad_in` at the end of T3 when no wait was inserted, or at the end of the last wait state otherwise. Values on `ad_in` at other clocks have no effect.
- R9: After T1, `as_out` carries the status code {zeros, io, write}: bit 0 is high for a write and bit 1 is high for I/O.
- R10: `m_io` (1 = I/O, 0 = memory) and `dt_r` (1 = transmit/write, 0 = receive/read) hold their values from T1 through T4. Both are low while idle.
- R11: `done` is high for exactly the one clock of T4, with `rdata` valid in that clock. The block is idle in the next clock.
- R12: While reset is applied, the block is idle. In that state `ale`, `ad_oe` and `done` are low, the active-low strobes are high, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept a request |
| req_addr | input | 20 | Transfer address |
| req_wdata | input | 16 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bhe | input | 1 | Upper data byte takes part in the transfer |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| rdata | output | 16 | Captured read data |
| done | output | 1 | One-clock pulse in T4 |
| ad_out | output | 16 | Value driven on the shared low lines |
| ad_oe | output | 1 | Output enable for the shared low lines |
| ad_in | input | 16 | Value seen on the shared low lines |
| as_out | output | 4 | Upper lines: address bits, then status |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Data buffer enable, active low |
| dt_r | output | 1 | Data direction |
| m_io | output | 1 | Memory or I/O space |
| bhe_n | output | 1 | High-byte enable, active low |
| ready | input | 1 | Device ready; low inserts wait states |

## Verification
The bench runs reads and writes in both address spaces, with and without the high byte, and with 0, 1, 2 and 5 wait states. Comparing cycle lengths shows whether `ready` is sampled at the right points and whether every sample counts. In one run `ready` is low only during T3, and that run must still take four clocks, which shows that T3 is never a sampling point. For reads, `ad_in` holds a decoy value in every clock except the capture clock, so capturing one clock early or late yields the wrong data. One run also raises a second request in mid-transfer, which must be refused and must not start an extra cycle.

// File: rtl/mux_bus_seq.sv
module mux_bus_seq #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_write,
  input  logic          req_bhe,
  input  logic          req_io,
  output logic [DW-1:0] rdata,
  output logic          done,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_in,
  output logic [AW-DW-1:0] as_out,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          den_n,
  output logic          dt_r,
  output logic          m_io,
  output logic          bhe_n,
  input  logic          ready
);
  localparam int UW = AW - DW;

  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_T3, S_TW, S_T4} phase_t;
  phase_t st;

  logic [AW-1:0] a_q;
  logic [DW-1:0] wd_q;
  logic          wr_q, bhe_q, io_q, rdy_q;
  logic          strobe;
  logic          capture;

  assign req_ready = (st == S_IDLE);
  assign capture   = !wr_q && ((st == S_T3 && rdy_q) || (st == S_TW && ready));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      a_q   <= '0;
      wd_q  <= '0;
      wr_q  <= 1'b0;
      bhe_q <= 1'b0;
      io_q  <= 1'b0;
      rdy_q <= 1'b1;
      rdata <= '0;
    end else begin
      if (capture) rdata <= ad_in;
      case (st)
        S_IDLE: if (req_valid) begin
          a_q   <= req_addr;
          wd_q  <= req_wdata;
          wr_q  <= req_write;
          bhe_q <= req_bhe;
          io_q  <= req_io;
          st    <= S_T1;
        end
        S_T1: st <= S_T2;
        S_T2: begin
          rdy_q <= ready;
          st    <= S_T3;
        end
        S_T3: st <= rdy_q ? S_T4 : S_TW;
        S_TW: if (ready) st <= S_T4;
        S_T4: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign strobe = (st == S_T2) || (st == S_T3) || (st == S_TW);
  assign ale    = (st == S_T1);
  assign done   = (st == S_T4);
  assign rd_n   = !(strobe && !wr_q);
  assign wr_n   = !(strobe && wr_q);
  assign den_n  = !strobe;
  assign dt_r   = (st != S_IDLE) && wr_q;
  assign m_io   = (st != S_IDLE) && io_q;
  assign bhe_n  = !(ale && bhe_q);
  assign ad_oe  = ale || (wr_q && (strobe || done));
  assign ad_out = ale ? a_q[DW-1:0] : (wr_q ? wd_q : '0);
  assign as_out = ale ? a_q[AW-1:DW] :
                  (st == S_IDLE) ? '0 : {{(UW-2){1'b0}}, io_q, wr_q};

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  // R2
  ale_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);
  // R4
  t4_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rd_n && wr_n && den_n));
  // R6
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);
  // R1
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ale);
  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (req_ready && !done));
  // R7
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TW && !ready) |=> (st == S_TW));
endmodule

// File: tb/mux_bus_seq_test.sv
module mux_bus_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_write = 1'b0, req_bhe = 1'b0, req_io = 1'b0;
  logic [15:0] rdata, ad_out, ad_in = '0;
  logic        done, ad_oe, ale, rd_n, wr_n, den_n, dt_r, m_io, bhe_n;
  logic [3:0]  as_out;
  logic        ready = 1'b1;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  mux_bus_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
    .req_bhe(req_bhe), .req_io(req_io), .rdata(rdata), .done(done),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .as_out(as_out),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n), .dt_r(dt_r),
    .m_io(m_io), .bhe_n(bhe_n), .ready(ready)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic reset_test();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R12 req_ready", req_ready, 1);
    chk(!ale && !ad_oe && !done, "R12 ale/oe/done", {ale, ad_oe, done}, 0);
    chk(rd_n && wr_n && den_n && bhe_n, "R12 strobes", {rd_n, wr_n, den_n, bhe_n}, 4'hf);
    chk(!dt_r && !m_io, "R10 idle dt_r/m_io", {dt_r, m_io}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // nwaits: wait states expected; t3_low: ready low during T3 only (no waits)
  task automatic run_cycle(input logic [19:0] a, input logic [15:0] wd,
                           input bit w, input bit bh, input bit io,
                           input int nwaits, input bit t3_low,
                           input logic [15:0] rd, input bit poke_busy);
    int len;
    bit act;
    len = 4 + nwaits;
    @(negedge clk);
    chk(req_ready, "R1 ready before request", req_ready, 1);
    req_valid = 1'b1; req_addr = a; req_wdata = wd;
    req_write = w; req_bhe = bh; req_io = io;
    ad_in = ~rd;
    for (int idx = 0; idx <= len; idx++) begin
      @(negedge clk);
      req_valid = 1'b0;
      req_addr = ~a; req_wdata = ~wd; req_write = ~w; req_io = ~io;
      if (poke_busy && idx == 1) begin
        req_valid = 1'b1;
        chk(!req_ready, "R1 busy req_ready", req_ready, 0);
      end
      if (nwaits > 0) ready = !(idx >= 1 && idx <= nwaits + 1);
      else ready = !(t3_low && idx == 2);
      ad_in = (idx == 2 + nwaits) ? rd : ~rd;
      if (idx == len) begin
        chk(req_ready && !done, "R11 idle after T4", {req_ready, done}, 2);
        chk(rd_n && wr_n && den_n, "R4 idle strobes", {rd_n, wr_n, den_n}, 7);
        chk(!dt_r && !m_io, "R10 idle dt_r/m_io", {dt_r, m_io}, 0);
        break;
      end
      act = (idx >= 1 && idx <= len - 2);
      chk(ale == (idx == 0), "R2 ale", ale, idx == 0);
      chk(bhe_n == !(idx == 0 && bh), "R3 bhe_n", bhe_n, !(idx == 0 && bh));
      chk(rd_n == !(act && !w), "R4 rd_n", rd_n, !(act && !w));
      chk(wr_n == !(act && w), "R4 wr_n", wr_n, !(act && w));
      chk(den_n == !act, "R4 den_n", den_n, !act);
      chk(m_io == io && dt_r == w, "R10 m_io/dt_r", {m_io, dt_r}, {io, w});
      chk(done == (idx == len - 1), "R7 R11 done timing", done, idx == len - 1);
      if (idx == 0) begin
        chk(ad_oe && ad_out == a[15:0], "R2 address phase", {ad_oe, ad_out}, {1'b1, a[15:0]});
        chk(as_out == a[19:16], "R2 upper address", as_out, a[19:16]);
      end else begin
        chk(as_out == {2'b00, io, w}, "R9 status", as_out, {2'b00, io, w});
        if (w)
          chk(ad_oe && ad_out == wd, "R5 write data", {ad_oe, ad_out}, {1'b1, wd});
        else
          chk(!ad_oe, "R6 released", ad_oe, 0);
      end
      if (idx == len - 1 && !w)
        chk(rdata == rd, "R8 read capture", rdata, rd);
    end
    ready = 1'b1;
    req_valid = 1'b0;
    if (poke_busy) begin
      repeat (3) begin
        @(negedge clk);
        chk(!ale && req_ready, "R1 busy request ignored", {ale, req_ready}, 1);
      end
    end
  endtask

  initial begin
    #20000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    reset_test();
    run_cycle(20'hA1234, 16'h0, 1'b0, 1'b1, 1'b0, 0, 1'b0, 16'hBEEF, 1'b0);
    run_cycle(20'h5F00D, 16'hC0DE, 1'b1, 1'b0, 1'b0, 0, 1'b0, 16'h0, 1'b0);
    run_cycle(20'h00310, 16'h0, 1'b0, 1'b0, 1'b1, 1, 1'b0, 16'h1357, 1'b0);
    run_cycle(20'hFFFFE, 16'h8001, 1'b1, 1'b1, 1'b1, 2, 1'b0, 16'h0, 1'b0);
    run_cycle(20'h3C3C3, 16'h0, 1'b0, 1'b1, 1'b0, 5, 1'b0, 16'h2468, 1'b0);
    run_cycle(20'h12345, 16'h0, 1'b0, 1'b0, 1'b0, 0, 1'b1, 16'h9ABC, 1'b0);
    run_cycle(20'h7E001, 16'h55AA, 1'b1, 1'b0, 1'b1, 0, 1'b1, 16'h0, 1'b1);
    run_cycle(20'h80002, 16'h0, 1'b0, 1'b1, 1'b1, 1, 1'b0, 16'hF00F, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule